// File: doc/BRIEF.md
# Multi-mode programmable interval counter

This block is one down-counting timer channel with six operating modes. A host first writes a configuration word that selects the operating mode and the count format, binary or four-digit decimal. The host then writes a count value. The channel counts pulses on a clock-enable input (`tick`). It watches a `gate` input, which enables counting in some modes and triggers a start in others. It drives a single registered output `out`.

The modes are: a terminal-count flag, a retriggerable one-shot, a periodic rate generator, a square wave, a strobe started by software and a strobe started by hardware. Each mode has its own rule for when a count loads, whether `gate` enables counting or triggers it, and how `out` moves. The edge counts are exact: in some modes an event lands N ticks after the load and in others N+1.

Timing convention. `out` changes on the clock edge of a cycle in which `tick` is high. A write changes it one clock after the write cycle. A rising edge on `gate` is registered one clock after `gate` rises, and takes effect on the next tick after that.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is low and no count is held, so ticks alone leave `out` low.
- R2: A configuration write with mode code 0 drives `out` low; any other code drives it high. A count write in mode 0 drives `out` low and restarts the count. A count write in mode 4 restarts it with `out` high.
- R3: In mode 0 the first tick after a count write of N loads the count even if `gate` is low. `out` rises on the (N+1)th tick, counting only ticks with `gate` high after the load. It then stays high until the next write.
- R4: In mode 1 a `gate` rising edge makes the next tick load the count and drive `out` low. `out` returns high after N further ticks. A new rising edge during the pulse restarts it. Ticks without a trigger do nothing.
- R5: In mode 2 (codes 2 and 6, N of at least 2) the first tick loads N with `out` high. `out` is then low for exactly one tick every N ticks, and returns high as the count reloads.
- R6: In mode 3 (codes 3 and 7, N of at least 2) `out` is a square wave with a period of N ticks. It is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high at the loading tick.
- R7: In mode 4, with `gate` high, `out` goes low on the (N+1)th tick after a count write and returns high on the next tick.
- R8: In mode 5 a `gate` rising edge makes the next tick load the count. `out` goes low on the (N+1)th tick after the trigger and high again one tick later.
- R9: In modes 2 and 3, `gate` low forces `out` high on the next clock and suspends counting. A `gate` rising edge reloads the count on the next tick, which restarts the period.
- R10: When the configuration word selects decimal format (`cfg_bcd`=1), the count value is four decimal digits: bits 3:0 are the ones digit, 7:4 the tens, 11:8 the hundreds and 15:12 the thousands.
- R11: A count value of 0 acts as 65536 in binary format and as 10000 in decimal format.
- R12: Cycles with `tick` low change `out` only through writes and the forcing rule of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable pulse, one clock wide per counted pulse |
| gate | input | 1 | Gate level and trigger input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Operating mode code 0..7 (6 and 7 alias 2 and 3) |
| cfg_bcd | input | 1 | Count format: 1 = four decimal digits, 0 = binary |
| cnt_we | input | 1 | Count value write strobe |
| cnt_val | input | CW (16) | Count value |
| out | output | 1 | Registered counter output |

## Verification
The bench builds the channel with its default 16-bit count width. With this width, a zero count means 65536 binary pulses or 10000 decimal pulses. Because `tick` is held high on back-to-back clocks, both full-range cases fit in the run and are checked at their exact terminal tick. The narrow width of the decimal digit fields lets small hand-picked values such as 0x0012 and 0x0100 show that the digits are weighted decimally rather than in binary.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC     = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } pit_mode_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic pit_mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction

  function automatic int pow10(input int e);
    int r;
    r = 1;
    for (int k = 0; k < e; k++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  // reset high so a gate already high at reset is not a trigger
  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/pit_count_load.sv
module pit_count_load import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] val,
  input  logic          bcd,
  output logic [CW:0]   len
);
  localparam int DIGITS = CW / 4;
  localparam int LW = CW + 1;
  localparam logic [LW-1:0] BIN_MAX = LW'(1) << CW;
  localparam logic [LW-1:0] DEC_MAX = LW'(pow10(DIGITS));

  logic [LW-1:0] part [DIGITS];
  logic [LW-1:0] dsum;

  genvar g;
  for (g = 0; g < DIGITS; g++) begin : g_dig
    localparam logic [LW-1:0] WEIGHT = LW'(pow10(g));
    assign part[g] = LW'(val[4*g +: 4]) * WEIGHT;
  end

  always_comb begin
    dsum = '0;
    for (int i = 0; i < DIGITS; i++) dsum = dsum + part[i];
  end

  always_comb begin
    if (val == '0) len = bcd ? DEC_MAX : BIN_MAX;
    else           len = bcd ? dsum : {1'b0, val};
  end
endmodule

// File: rtl/pit_core.sv
module pit_core import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      gate,
  input  logic      rise,
  input  logic      cfg_we,
  input  pit_mode_e cfg_mode,
  input  logic      cnt_we,
  input  logic [CW:0] len_in,
  output logic      out
);
  localparam int LW = CW + 1;
  localparam logic [LW-1:0] ONE = LW'(1);
  localparam logic [LW-1:0] TWO = LW'(2);

  pit_mode_e     mode_q;
  logic [LW-1:0] reload_q, cnt_q;
  logic          pend_q, has_q, run_q, trig_q, out_q;
  logic          is_per;
  logic [LW-1:0] hi_len, lo_len;

  assign is_per = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign hi_len = (reload_q + ONE) >> 1;
  assign lo_len = reload_q >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_TC;
      reload_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      has_q    <= 1'b0;
      run_q    <= 1'b0;
      trig_q   <= 1'b0;
      out_q    <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      out_q  <= (cfg_mode != M_TC);
      pend_q <= 1'b0;
      has_q  <= 1'b0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
    end else if (cnt_we) begin
      reload_q <= len_in;
      has_q    <= 1'b1;
      if (mode_q == M_TC || mode_q == M_SWSTB) begin
        pend_q <= 1'b1;
        run_q  <= 1'b0;
        out_q  <= (mode_q != M_TC);
      end else if (is_per && !run_q) begin
        pend_q <= 1'b1;
      end
    end else begin
      if (rise) trig_q <= 1'b1;
      if (is_per && !gate) begin
        out_q <= 1'b1;
      end else if (tick) begin
        case (mode_q)
          M_TC: begin
            if (pend_q) begin
              cnt_q <= reload_q; pend_q <= 1'b0; run_q <= 1'b1;
            end else if (run_q && gate) begin
              if (cnt_q == ONE) begin out_q <= 1'b1; run_q <= 1'b0; end
              else cnt_q <= cnt_q - ONE;
            end
          end
          M_SWSTB: begin
            if (pend_q) begin
              cnt_q <= reload_q; pend_q <= 1'b0; run_q <= 1'b1;
            end else if (run_q && (gate || !out_q)) begin
              if (!out_q) begin out_q <= 1'b1; run_q <= 1'b0; end
              else if (cnt_q == ONE) out_q <= 1'b0;
              else cnt_q <= cnt_q - ONE;
            end
          end
          M_ONESHOT: begin
            if (trig_q && has_q) begin
              cnt_q <= reload_q; run_q <= 1'b1; trig_q <= 1'b0; out_q <= 1'b0;
            end else if (run_q) begin
              if (cnt_q == ONE) begin out_q <= 1'b1; run_q <= 1'b0; end
              else cnt_q <= cnt_q - ONE;
            end
          end
          M_HWSTB: begin
            if (trig_q && has_q) begin
              cnt_q <= reload_q; run_q <= 1'b1; trig_q <= 1'b0; out_q <= 1'b1;
            end else if (run_q) begin
              if (!out_q) begin out_q <= 1'b1; run_q <= 1'b0; end
              else if (cnt_q == ONE) out_q <= 1'b0;
              else cnt_q <= cnt_q - ONE;
            end
          end
          M_RATE: begin
            if (pend_q || trig_q) begin
              cnt_q <= reload_q; out_q <= 1'b1; run_q <= 1'b1;
              pend_q <= 1'b0; trig_q <= 1'b0;
            end else if (run_q) begin
              if (cnt_q <= ONE) begin
                cnt_q <= reload_q; out_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == TWO) out_q <= 1'b0;
              end
            end
          end
          M_SQUARE: begin
            if (pend_q || trig_q) begin
              cnt_q <= hi_len; out_q <= 1'b1; run_q <= 1'b1;
              pend_q <= 1'b0; trig_q <= 1'b0;
            end else if (run_q) begin
              if (cnt_q <= ONE) begin
                out_q <= !out_q;
                cnt_q <= out_q ? lo_len : hi_len;
              end else begin
                cnt_q <= cnt_q - ONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out = out_q;

  // R2: configuration write sets the output level from the mode code
  a_r2_cfg_level: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (out_q == ($past(cfg_mode) != M_TC)));

  // R2: a count write in mode 0 pulls the output low
  a_r2_tc_write_low: assert property (@(posedge clk) disable iff (rst)
    (cnt_we && !cfg_we && mode_q == M_TC) |=> !out_q);

  // R3: once high in mode 0 the output holds until a write
  a_r3_tc_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_TC && out_q && !cfg_we && !cnt_we) |=> out_q);

  // R7: strobes in modes 4 and 5 last one tick
  a_r7_strobe_one_tick: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SWSTB || mode_q == M_HWSTB) && !out_q && tick && !cfg_we && !cnt_we)
      |=> out_q);

  // R9: gate low in the periodic modes forces the output high
  a_r9_gate_forces_high: assert property (@(posedge clk) disable iff (rst)
    (is_per && !gate && !cfg_we && !cnt_we) |=> out_q);

  // R12: no tick, no write, no forcing: output holds
  a_r12_tick_only: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cfg_we && !cnt_we && !(is_per && !gate)) |=> $stable(out_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bcd,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_val,
  output logic          out
);
  logic        bcd_q;
  logic        rise;
  logic [CW:0] len;
  pit_mode_e   mode_n;

  always_ff @(posedge clk) begin
    if (rst)         bcd_q <= 1'b0;
    else if (cfg_we) bcd_q <= cfg_bcd;
  end

  assign mode_n = norm_mode(cfg_mode);

  pit_gate_edge u_gate (
    .clk  (clk),
    .rst  (rst),
    .gate (gate),
    .rise (rise)
  );

  pit_count_load #(.CW(CW)) u_load (
    .val (cnt_val),
    .bcd (bcd_q),
    .len (len)
  );

  pit_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .gate     (gate),
    .rise     (rise),
    .cfg_we   (cfg_we),
    .cfg_mode (mode_n),
    .cnt_we   (cnt_we),
    .len_in   (len),
    .out      (out)
  );

  // R1: output is low straight after reset
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !out);
endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic gate = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_bcd = 1'b0;
  logic cnt_we = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pit_channel #(.CW(16)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cnt_we(cnt_we),
    .cnt_val(cnt_val), .out(out)
  );

  // mode[36:34] bcd[33] value[32:17] ticks-to-event[16:0]
  localparam logic [36:0] VEC [6] = '{
    {3'd0, 1'b0, 16'd3,      17'd4},    // R3 binary
    {3'd0, 1'b1, 16'h0012,   17'd13},   // R10 twelve
    {3'd0, 1'b0, 16'd1,      17'd2},    // R3 shortest
    {3'd4, 1'b0, 16'd5,      17'd6},    // R7
    {3'd4, 1'b1, 16'h0010,   17'd11},   // R7 R10
    {3'd0, 1'b1, 16'h0100,   17'd101}   // R10 hundred
  };

  task automatic chk(input string req, input logic exp);
    total++;
    if (out !== exp) begin
      bad++;
      $display("FAIL %s out=%b expected=%b t=%0t", req, out, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] m, input logic b);
    @(negedge clk) begin cfg_mode = m; cfg_bcd = b; cfg_we = 1'b1; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk) begin cnt_val = v; cnt_we = 1'b1; end
    @(negedge clk) cnt_we = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk) gate = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset", 1'b0);
    tick_n(5);
    chk("R1 no count", 1'b0);

    for (int i = 0; i < 6; i++) begin
      logic [2:0] m;
      logic [16:0] e;
      m = VEC[i][36:34];
      e = VEC[i][16:0];
      wr_cfg(m, VEC[i][33]);
      wr_cnt(VEC[i][32:17]);
      tick_n(int'(e) - 1);
      chk("R3/R7/R10 before event", m != 3'd0);
      tick_n(1);
      chk("R3/R7/R10 at event", m == 3'd0);
      if (m == 3'd4) begin
        tick_n(1);
        chk("R7 strobe end", 1'b1);
      end
    end

    // R3 hold high, R2 rewrite restarts
    wr_cfg(3'd0, 1'b0);
    chk("R2 mode0 cfg low", 1'b0);
    wr_cnt(16'd2);
    tick_n(3);
    chk("R3 high at N+1", 1'b1);
    tick_n(20);
    chk("R3 stays high", 1'b1);
    wr_cnt(16'd2);
    chk("R2 count write low", 1'b0);
    tick_n(2);
    chk("R3 restart low", 1'b0);
    tick_n(1);
    chk("R3 restart high", 1'b1);

    // R3 gate pause
    wr_cnt(16'd3);
    set_gate(1'b0);
    tick_n(10);
    chk("R3 paused", 1'b0);
    set_gate(1'b1);
    tick_n(2);
    chk("R3 resumed low", 1'b0);
    tick_n(1);
    chk("R3 resumed high", 1'b1);

    // R12 no tick, no progress
    wr_cnt(16'd2);
    repeat (50) @(negedge clk);
    chk("R12 idle clocks", 1'b0);
    tick_n(3);
    chk("R12 ticks count", 1'b1);

    // R4 one-shot
    set_gate(1'b0);
    wr_cfg(3'd1, 1'b0);
    chk("R2 mode1 cfg high", 1'b1);
    wr_cnt(16'd4);
    tick_n(3);
    chk("R4 no trigger", 1'b1);
    set_gate(1'b1);
    tick_n(1);
    chk("R4 pulse starts", 1'b0);
    tick_n(3);
    chk("R4 pulse holds", 1'b0);
    tick_n(1);
    chk("R4 pulse ends", 1'b1);
    set_gate(1'b0); set_gate(1'b1);
    tick_n(1);
    tick_n(2);
    chk("R4 second pulse", 1'b0);
    set_gate(1'b0); set_gate(1'b1);
    tick_n(1);
    tick_n(3);
    chk("R4 retrigger extends", 1'b0);
    tick_n(1);
    chk("R4 retrigger end", 1'b1);

    // R8 hardware strobe
    set_gate(1'b0);
    wr_cfg(3'd5, 1'b0);
    wr_cnt(16'd3);
    set_gate(1'b1);
    tick_n(3);
    chk("R8 before strobe", 1'b1);
    tick_n(1);
    chk("R8 strobe", 1'b0);
    tick_n(1);
    chk("R8 strobe end", 1'b1);

    // R5 rate generator, R9 gate
    wr_cfg(3'd2, 1'b0);
    chk("R2 mode2 cfg high", 1'b1);
    wr_cnt(16'd4);
    tick_n(1);
    chk("R5 load high", 1'b1);
    tick_n(2);
    chk("R5 counting high", 1'b1);
    tick_n(1);
    chk("R5 low pulse", 1'b0);
    tick_n(1);
    chk("R5 reload high", 1'b1);
    tick_n(2);
    chk("R5 second period high", 1'b1);
    tick_n(1);
    chk("R5 second low", 1'b0);
    set_gate(1'b0);
    chk("R9 gate low forces high", 1'b1);
    tick_n(5);
    chk("R9 suspended", 1'b1);
    set_gate(1'b1);
    tick_n(1);
    chk("R9 reload high", 1'b1);
    tick_n(2);
    chk("R9 restarted high", 1'b1);
    tick_n(1);
    chk("R9 restarted low", 1'b0);

    // R6 square wave, odd N
    wr_cfg(3'd3, 1'b0);
    wr_cnt(16'd5);
    tick_n(1);
    chk("R6 load high", 1'b1);
    tick_n(2);
    chk("R6 high half", 1'b1);
    tick_n(1);
    chk("R6 low half", 1'b0);
    tick_n(1);
    chk("R6 low half end", 1'b0);
    tick_n(1);
    chk("R6 high again", 1'b1);
    tick_n(3);
    chk("R6 low again", 1'b0);
    set_gate(1'b0);
    chk("R9 square forced high", 1'b1);
    set_gate(1'b1);
    tick_n(1);
    chk("R9 square reload", 1'b1);
    tick_n(2);
    chk("R9 square high half", 1'b1);
    tick_n(1);
    chk("R9 square low", 1'b0);

    // R6 even N through alias code 7
    wr_cfg(3'd7, 1'b0);
    wr_cnt(16'd4);
    tick_n(1);
    chk("R6 alias load", 1'b1);
    tick_n(1);
    chk("R6 even high", 1'b1);
    tick_n(1);
    chk("R6 even low", 1'b0);
    tick_n(1);
    chk("R6 even low end", 1'b0);
    tick_n(1);
    chk("R6 even high again", 1'b1);

    // R11 zero counts
    wr_cfg(3'd0, 1'b0);
    wr_cnt(16'd0);
    tick_n(65536);
    chk("R11 binary zero before", 1'b0);
    tick_n(1);
    chk("R11 binary zero at 65537", 1'b1);
    wr_cfg(3'd0, 1'b1);
    wr_cnt(16'd0);
    tick_n(10000);
    chk("R11 decimal zero before", 1'b0);
    tick_n(1);
    chk("R11 decimal zero at 10001", 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule